// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It reads two 32-bit entries from a page table held in external memory. The address splits into three fields. Bits 31..22 index a directory. Bits 21..12 index a second-level table. Bits 11..0 are the byte offset inside a 4 KB page. The directory is located through a 20-bit frame register, the only fixed starting point. The upper 20 bits of a directory entry give the frame that holds the second-level table. The upper 20 bits of a table entry give the frame of the data page.

Each request carries an access kind. The walker checks the presence bit of both entries and the permission bits of the final entry. If the access is allowed, it sets the referenced bit, and for writes also the modified bit. It writes the entry back only when one of those bits actually changes. The walker serves one request at a time. It then reports either the physical address or a fault code with a one-cycle completion pulse.

Entry bit layout (both levels): bit 0 present, bit 1 read allowed, bit 2 write allowed, bit 3 execute allowed, bit 4 referenced, bit 5 modified, bit 6 cache disable, bits 31..12 frame number. Access kinds: 0 read, 1 write, 2 fetch, 3 treated as read. Fault codes: 0 none, 1 not present, 2 protection.

Top module: `pt_walker`

## Requirements
- R1: The first memory access of a walk is a read of address {directory frame register, vaddr[31:22], 2'b00}.
- R2: When the directory entry has bit 0 set, the second access is a read of address {dir_entry[31:12], vaddr[21:12], 2'b00}.
- R3: If bit 0 of the directory entry or of the table entry is clear, the walk ends with fault 1 and paddr 0, and it makes no further memory access.
- R4: A read (kind 0 or 3) needs table entry bit 1, a write (kind 1) needs bit 2 and a fetch (kind 2) needs bit 3. If the needed bit is clear, the walk ends with fault 2 and paddr 0, and nothing is written back.
- R5: A successful walk ends with fault 0 and paddr = {pte[31:12], vaddr[11:0]}.
- R6: On success, the entry value written back has bit 4 set. Bit 5 is set in that value only for a write, and all other bits are unchanged.
- R7: A successful walk writes the table entry back to its own address exactly once when bit 4 or bit 5 changes, and never when neither changes.
- R8: busy is high from the cycle after a request is accepted until done. A request presented while busy is ignored.
- R9: done is a single-cycle pulse, and busy is low in that cycle. paddr and fault keep their values until the next done.
- R10: frame_we loads the directory frame register only while the walker is idle. A load attempted while busy has no effect on later walks.
- R11: While mem_req is high and mem_ack is low, mem_req, mem_we, mem_addr and mem_wdata stay unchanged.
- R12: After reset, busy, done and mem_req are low, fault is 0, paddr is 0 and the directory frame register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_we | input | 1 | Load the directory frame register (taken only when idle) |
| frame_in | input | 20 | New directory frame number |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| paddr | output | 32 | Physical address, valid when fault is 0 |
| fault | output | 2 | 0 none, 1 not present, 2 protection |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | The access is a write |
| mem_addr | output | 32 | Byte address of the 32-bit entry |
| mem_wdata | output | 32 | Entry value to write back |
| mem_ack | input | 1 | Memory completes the current access in this cycle |
| mem_rdata | input | 32 | Read data, valid in the cycle mem_ack is high |

## Verification
The hardest case to reach is the write-back decision. It needs a present directory entry and a present table entry whose permission matches the access kind. The referenced and modified bits must then be pre-set in exactly the combination that does or does not force a write. The bench fills memory with entries whose flag bits are drawn at random, with presence mostly set, and varies the access kind. Directed walks add the already-referenced read, the already-dirty write and each single missing permission. Random memory latency holds each request for a variable number of cycles, so the walker's hold-until-acknowledge behaviour is exercised on every access.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_we,
  input  logic [31-OFF_W:0]         frame_in,
  input  logic                      req_valid,
  input  logic [31:0]               req_vaddr,
  input  logic [1:0]                req_kind,
  output logic                      busy,
  output logic                      done,
  output logic [31:0]               paddr,
  output logic [1:0]                fault,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [31:0]               mem_addr,
  output logic [31:0]               mem_wdata,
  input  logic                      mem_ack,
  input  logic [31:0]               mem_rdata
);
  localparam int FN_W  = 32 - OFF_W;
  localparam int TOP_L = OFF_W + IDX_W;
  localparam int B_V = 0, B_R = 1, B_W = 2, B_X = 3, B_REF = 4, B_MOD = 5;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_PTE, S_WB} st_t;
  st_t              st;
  logic [31:0]      va_q;
  logic [1:0]       kind_q;
  logic [FN_W-1:0]  base_q, tbl_q, ppn_q;
  logic [31:0]      pte_q;
  logic             allowed;
  logic [31:0]      upd;

  always_comb begin
    case (kind_q)
      2'd1:    allowed = mem_rdata[B_W];
      2'd2:    allowed = mem_rdata[B_X];
      default: allowed = mem_rdata[B_R];
    endcase
    upd = mem_rdata;
    upd[B_REF] = 1'b1;
    if (kind_q == 2'd1) upd[B_MOD] = 1'b1;
  end

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WB);
  assign mem_wdata = pte_q;

  always_comb begin
    case (st)
      S_DIR:   mem_addr = {base_q, va_q[31:TOP_L], 2'b00};
      S_PTE,
      S_WB:    mem_addr = {tbl_q, va_q[TOP_L-1:OFF_W], 2'b00};
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; va_q <= '0; kind_q <= '0; base_q <= '0; tbl_q <= '0;
      ppn_q <= '0; pte_q <= '0; paddr <= '0; fault <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (frame_we && st == S_IDLE) base_q <= frame_in;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr; kind_q <= req_kind; st <= S_DIR;
        end
        S_DIR: if (mem_ack) begin
          if (!mem_rdata[B_V]) begin
            st <= S_IDLE; done <= 1'b1; fault <= 2'd1; paddr <= '0;
          end else begin
            tbl_q <= mem_rdata[31:OFF_W]; st <= S_PTE;
          end
        end
        S_PTE: if (mem_ack) begin
          if (!mem_rdata[B_V]) begin
            st <= S_IDLE; done <= 1'b1; fault <= 2'd1; paddr <= '0;
          end else if (!allowed) begin
            st <= S_IDLE; done <= 1'b1; fault <= 2'd2; paddr <= '0;
          end else if (upd != mem_rdata) begin
            pte_q <= upd; ppn_q <= mem_rdata[31:OFF_W]; st <= S_WB;
          end else begin
            st <= S_IDLE; done <= 1'b1; fault <= 2'd0;
            paddr <= {mem_rdata[31:OFF_W], va_q[OFF_W-1:0]};
          end
        end
        S_WB: if (mem_ack) begin
          st <= S_IDLE; done <= 1'b1; fault <= 2'd0;
          paddr <= {ppn_q, va_q[OFF_W-1:0]};
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_fault_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fault != 2'd3);
  p_wb_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req && mem_wdata[B_REF]);
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> done || ($stable(paddr) && $stable(fault)));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic clk = 0, rst_n = 0;
  logic frame_we = 0; logic [19:0] frame_in = '0;
  logic req_valid = 0; logic [31:0] req_vaddr = '0; logic [1:0] req_kind = '0;
  logic busy, done, mem_req, mem_we, mem_ack = 0;
  logic [31:0] paddr, mem_addr, mem_wdata, mem_rdata = '0;
  logic [1:0] fault;

  pt_walker dut (.clk, .rst_n, .frame_we, .frame_in, .req_valid, .req_vaddr, .req_kind,
    .busy, .done, .paddr, .fault, .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mem_ack, .mem_rdata);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] mem [0:4095];
  logic [31:0] lg_a [0:7]; logic lg_w [0:7]; logic [31:0] lg_d [0:7]; int lg_n = 0;
  logic [31:0] ex_a [0:7]; logic ex_w [0:7]; logic [31:0] ex_d [0:7]; int ex_n;
  logic [31:0] ex_pa; logic [1:0] ex_f;
  logic [19:0] base_m = '0;
  int wait_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  // memory responder with random latency
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req) begin
        if (wait_cnt == 0) begin
          if (lg_n < 8) begin
            lg_a[lg_n] = mem_addr; lg_w[lg_n] = mem_we; lg_d[lg_n] = mem_wdata;
          end
          lg_n++;
          if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
          else mem_rdata = mem[mem_addr[13:2]];
          mem_ack = 1;
          wait_cnt = $urandom % 3;
        end else wait_cnt--;
      end
    end
  end

  task automatic expect_walk(input logic [31:0] va, input logic [1:0] k);
    logic [31:0] d, p, n; logic ok;
    ex_n = 0; ex_pa = '0;
    ex_a[0] = {base_m, va[31:22], 2'b00}; ex_w[0] = 0; ex_d[0] = '0; ex_n = 1;  // R1
    d = mem[ex_a[0][13:2]];
    if (!d[0]) begin ex_f = 2'd1; return; end
    ex_a[1] = {d[31:12], va[21:12], 2'b00}; ex_w[1] = 0; ex_d[1] = '0; ex_n = 2;  // R2
    p = mem[ex_a[1][13:2]];
    if (!p[0]) begin ex_f = 2'd1; return; end
    ok = (k == 2'd1) ? p[2] : (k == 2'd2) ? p[3] : p[1];
    if (!ok) begin ex_f = 2'd2; return; end
    n = p | 32'h10 | ((k == 2'd1) ? 32'h20 : 32'h0);
    if (n != p) begin ex_a[2] = ex_a[1]; ex_w[2] = 1; ex_d[2] = n; ex_n = 3; end  // R6 R7
    ex_f = 2'd0; ex_pa = {p[31:12], va[11:0]};
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] k);
    int t;
    logic [31:0] held_pa; logic [1:0] held_f;
    expect_walk(va, k);
    @(negedge clk);
    lg_n = 0;
    req_valid = 1; req_vaddr = va; req_kind = k;
    @(negedge clk);
    req_valid = 0;
    chk(busy === 1'b1, "R8 busy after accept", {31'd0, busy}, 32'd1);
    // a second request while busy must be ignored (R8)
    req_valid = 1; req_vaddr = ~va; req_kind = ~k;
    @(negedge clk);
    req_valid = 0;
    t = 0;
    while (done !== 1'b1 && t < 200) begin @(negedge clk); t++; end
    chk(done === 1'b1, "R8 walk completes", {31'd0, done}, 32'd1);
    chk(busy === 1'b0, "R9 idle at done", {31'd0, busy}, 32'd0);
    chk(fault === ex_f, "R3 R4 R5 fault code", {30'd0, fault}, {30'd0, ex_f});
    chk(paddr === ex_pa, "R5 physical address", paddr, ex_pa);
    chk(lg_n == ex_n, "R3 R7 R8 access count", lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n && i < 8; i++) begin
      chk(lg_a[i] === ex_a[i] && lg_w[i] === ex_w[i] && (!ex_w[i] || lg_d[i] === ex_d[i]),
          "R1 R2 R6 R7 R11 access", lg_w[i] ? lg_d[i] : lg_a[i], ex_w[i] ? ex_d[i] : ex_a[i]);
    end
    held_pa = paddr; held_f = fault;
    @(negedge clk);
    chk(done === 1'b0, "R9 done single pulse", {31'd0, done}, 32'd0);
    chk(paddr === held_pa && fault === held_f, "R9 result held", paddr, held_pa);
  endtask

  task automatic set_base(input logic [19:0] f);
    @(negedge clk); frame_we = 1; frame_in = f;
    @(negedge clk); frame_we = 0;
    base_m = f;
  endtask

  task automatic place(input logic [31:0] va, input logic [1:0] tf, input logic [31:0] pte, input bit dir_ok);
    mem[{base_m[1:0], va[31:22]}] = {12'd0, 6'd0, tf, 11'd0, dir_ok};
    mem[{tf, va[21:12]}] = pte;
  endtask

  initial begin
    logic [31:0] va, pte; logic [1:0] tf;
    void'($urandom(32'd7321));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && done === 0 && mem_req === 0, "R12 reset outputs", {29'd0, busy, done, mem_req}, 32'd0);
    chk(fault === 0 && paddr === 0, "R12 reset result", paddr, 32'd0);

    // directed corner cases
    va = 32'h0040_3abc;
    place(va, 2'd1, 32'hABCDE_003, 1'b0);             walk(va, 2'd0);  // R3 dir absent
    place(va, 2'd1, 32'hABCDE_002, 1'b1);             walk(va, 2'd0);  // R3 pte absent
    place(va, 2'd1, 32'hABCDE_00D, 1'b1);             walk(va, 2'd0);  // R4 read denied
    place(va, 2'd1, 32'hABCDE_00B, 1'b1);             walk(va, 2'd1);  // R4 write denied
    place(va, 2'd1, 32'hABCDE_007, 1'b1);             walk(va, 2'd2);  // R4 fetch denied
    place(va, 2'd2, 32'h12345_003, 1'b1);             walk(va, 2'd0);  // R6 R7 ref set
    walk(va, 2'd3);                                                    // R7 no rewrite
    place(va, 2'd3, 32'h54321_015, 1'b1);             walk(va, 2'd1);  // R6 modified
    walk(va, 2'd1);                                                    // R7 already dirty
    place(va, 2'd3, 32'h0F0F0_059, 1'b1);             walk(va, 2'd2);  // R6 fetch keeps M clear

    // R10 base register load while idle, ignored while busy
    set_base(20'd2);
    va = 32'hFFC0_1123;
    place(va, 2'd3, 32'h77777_013, 1'b1);
    fork
      walk(va, 2'd0);
      begin @(negedge clk); @(negedge clk); frame_we = 1; frame_in = 20'd1; @(negedge clk); frame_we = 0; end
    join
    walk(va, 2'd0);  // R10: still uses frame 2
    set_base(20'd0);

    // random walks
    for (int n = 0; n < 300; n++) begin
      va = $urandom;
      tf = 2'd1 + 2'($urandom % 3);
      pte = {20'($urandom), 5'd0, 7'($urandom)};
      if ($urandom % 8 != 0) pte[0] = 1'b1;
      place(va, tf, pte, ($urandom % 8) != 0);
      walk(va, 2'($urandom % 4));
    end
    finish_run();
  end
endmodule